// File: doc/BRIEF.md
# Paged Memory Window Address Translator

This block maps a 16-bit local processor address onto a 23-bit global address. Three 8-bit page registers each pick which block of the global space shows through a fixed window of the local map:

- the program page picks a 16 KB block,
- the data-RAM page picks a 4 KB block,
- the nonvolatile-data page picks a 1 KB block.

Two unpaged local regions land on fixed high global addresses. A one-bit map-select control moves one of those regions to a different global location. Every other local address passes straight into a fixed low global region.

The page registers and the map-select bit sit behind a small register bus. Writes are clocked and reads are combinational. A separate page-load port models the subroutine call and return path. It writes only the program page, and it wins over a bus write in the same cycle. The translation itself is combinational from the registered page values. Alongside the address, the block reports which kind of region the address hit.

Top module: `pgx_translator`

## Requirements
- R1: A local address in 0x8000–0xBFFF translates to {1'b1, program page, local[13:0]}, i.e. global 0x40_0000 + page*0x4000 + offset.
- R2: A local address in 0xC000–0xFFFF translates to 0x7F_C000 + local[13:0], whatever any page register or the map-select bit holds.
- R3: A local address in 0x4000–0x7FFF translates to 0x7F_4000 + local[13:0] when the map-select bit is 0, and to 0x14_4000 + local[13:0] when it is 1.
- R4: A local address in 0x1000–0x1FFF translates to {3'b000, RAM page, local[11:0]}.
- R5: A local address in 0x0800–0x0BFF translates to {5'b00100, nonvolatile page, local[9:0]}, i.e. 0x10_0000 + page*0x400 + offset.
- R6: Any other local address (0x0000–0x07FF, 0x0C00–0x0FFF, 0x2000–0x3FFF) translates to 0x7F_0000 + local.
- R7: A register-bus write (reg_wr high) to select 0 (program), 1 (RAM) or 2 (nonvolatile) stores reg_wdata in that page at the next clock edge. reg_rdata shows the selected register combinationally.
- R8: When ld_en is high, ld_page is stored into the program page at the next clock edge. If a bus write to select 0 happens in the same cycle, the load value wins.
- R9: After reset the program page reads 0xFE, the RAM page 0xFD, the nonvolatile page 0xFE and the map-select register 0x00.
- R10: The region output is 0 for the program window, 1 for the RAM window, 2 for the nonvolatile window, 3 for either unpaged region (0x4000–0x7FFF or 0xC000–0xFFFF) and 4 for any other address.
- R11: Select 3 holds only the map-select bit in bit 0 and reads 0 in bits 7:1. A write to select 3 leaves all three page registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register-bus write strobe |
| reg_sel | input | 2 | Register select: 0 program, 1 RAM, 2 nonvolatile, 3 map-select |
| reg_wdata | input | 8 | Register-bus write data |
| reg_rdata | output | 8 | Register-bus read data for reg_sel |
| ld_en | input | 1 | Call/return program-page load strobe |
| ld_page | input | 8 | Program-page value to load |
| loc_addr | input | 16 | Local address to translate |
| glb_addr | output | 23 | Translated global address |
| region | output | 3 | Region hit code |

## Verification
The bench probes the first and last byte of every window. A decoder that uses the wrong bit boundary would therefore put an edge address into a neighbouring region and give the wrong region code. It writes the same program-page cycle from both the bus and the load port. A design that gave priority to the bus would translate with the bus value. It flips the map-select bit and checks both the relocated region and the top unpaged region. A design that tied the wrong region to the bit, or let the program page leak into 0xC000–0xFFFF, would produce a shifted high address. It also writes the map-select register with all data bits set, which exposes a design that stores extra bits or corrupts a page register.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    localparam int LOC_W = 16;
    localparam int PG_W  = 8;
    localparam int GLB_W = 23;
    localparam int NPAGE = 3;

    typedef enum logic [2:0] {
        WIN_PROG  = 3'd0,
        WIN_RAM   = 3'd1,
        WIN_EEP   = 3'd2,
        WIN_FIXED = 3'd3,
        WIN_OTHER = 3'd4
    } win_e;

    typedef enum logic [1:0] {
        SEL_PROG = 2'd0,
        SEL_RAM  = 2'd1,
        SEL_EEP  = 2'd2,
        SEL_CTL  = 2'd3
    } sel_e;

    // Upper bits (above the 16 KB offset) of the fixed global targets.
    localparam logic [8:0] TOP_FIXED_HI  = 9'h1FF;  // 0x7F_C000
    localparam logic [8:0] MID_FIXED_LO  = 9'h1FD;  // 0x7F_4000
    localparam logic [8:0] MID_FIXED_ALT = 9'h051;  // 0x14_4000
    localparam logic [6:0] PASS_PREFIX   = 7'h7F;   // 0x7F_0000
    localparam logic [4:0] EEP_PREFIX    = 5'b00100; // 0x10_0000
    localparam logic [2:0] RAM_PREFIX    = 3'b000;

endpackage

// File: rtl/pgx_page_bank.sv
module pgx_page_bank
    import pgx_pkg::*;
#(
    parameter int                    PW      = PG_W,
    parameter int                    NP      = NPAGE,
    parameter logic [NPAGE*PG_W-1:0] RST_VAL = {8'hFE, 8'hFD, 8'hFE}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [PW-1:0]    reg_wdata,
    input  logic             ld_en,
    input  logic [PW-1:0]    ld_page,
    output logic [NP*PW-1:0] pages,
    output logic             hi_map,
    output logic [PW-1:0]    reg_rdata
);

    localparam int TOTAL_W = NP * PW;

    logic [TOTAL_W-1:0] pg_q;

    // One register per page; index 0 is the program page and also takes the load port.
    genvar gi;
    generate
        for (gi = 0; gi < NP; gi++) begin : g_page
            logic          bus_hit;
            logic [PW-1:0] nxt;
            logic          upd;

            assign bus_hit = reg_wr && (reg_sel == 2'(gi));

            if (gi == 0) begin : g_prog
                always_comb begin
                    upd = ld_en || bus_hit;
                    nxt = ld_en ? ld_page : reg_wdata;
                end
            end else begin : g_plain
                always_comb begin
                    upd = bus_hit;
                    nxt = reg_wdata;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pg_q[gi*PW +: PW] <= RST_VAL[gi*PW +: PW];
                end else if (upd) begin
                    pg_q[gi*PW +: PW] <= nxt;
                end
            end
        end
    endgenerate

    // Map-select control bit.
    logic hi_map_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_map_q <= 1'b0;
        end else if (reg_wr && reg_sel == SEL_CTL) begin
            hi_map_q <= reg_wdata[0];
        end
    end

    always_comb begin
        unique case (sel_e'(reg_sel))
            SEL_PROG: reg_rdata = pg_q[0*PW +: PW];
            SEL_RAM:  reg_rdata = pg_q[1*PW +: PW];
            SEL_EEP:  reg_rdata = pg_q[2*PW +: PW];
            SEL_CTL:  reg_rdata = {{(PW-1){1'b0}}, hi_map_q};
            default:  reg_rdata = '0;
        endcase
    end

    assign pages  = pg_q;
    assign hi_map = hi_map_q;

endmodule

// File: rtl/pgx_win_decode.sv
module pgx_win_decode
    import pgx_pkg::*;
#(
    parameter int LW = LOC_W
) (
    input  logic [LW-1:0] loc,
    output win_e          win
);

    localparam int TOP = LW - 1;

    // Windows are disjoint; the six upper address bits resolve every one of them.
    always_comb begin
        unique casez (loc[TOP -: 6])
            6'b11????: win = WIN_FIXED;
            6'b10????: win = WIN_PROG;
            6'b01????: win = WIN_FIXED;
            6'b0001??: win = WIN_RAM;
            6'b000010: win = WIN_EEP;
            default:   win = WIN_OTHER;
        endcase
    end

endmodule

// File: rtl/pgx_addr_compose.sv
module pgx_addr_compose
    import pgx_pkg::*;
#(
    parameter int LW = LOC_W,
    parameter int PW = PG_W,
    parameter int GW = GLB_W
) (
    input  win_e             win,
    input  logic [LW-1:0]    loc,
    input  logic [3*PW-1:0]  pages,
    input  logic             hi_map,
    output logic [GW-1:0]    glb
);

    logic [PW-1:0] prog_pg;
    logic [PW-1:0] ram_pg;
    logic [PW-1:0] eep_pg;
    logic [8:0]    fixed_hi;

    assign prog_pg = pages[0*PW +: PW];
    assign ram_pg  = pages[1*PW +: PW];
    assign eep_pg  = pages[2*PW +: PW];

    // Upper-half unpaged block is fixed; the lower one follows the map-select bit.
    always_comb begin
        if (loc[LW-1])       fixed_hi = TOP_FIXED_HI;
        else if (hi_map)     fixed_hi = MID_FIXED_ALT;
        else                 fixed_hi = MID_FIXED_LO;
    end

    always_comb begin
        unique case (win)
            WIN_PROG:  glb = {1'b1, prog_pg, loc[13:0]};
            WIN_RAM:   glb = {RAM_PREFIX, ram_pg, loc[11:0]};
            WIN_EEP:   glb = {EEP_PREFIX, eep_pg, loc[9:0]};
            WIN_FIXED: glb = {fixed_hi, loc[13:0]};
            WIN_OTHER: glb = {PASS_PREFIX, loc};
            default:   glb = {PASS_PREFIX, loc};
        endcase
    end

endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
    import pgx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [PG_W-1:0]    reg_wdata,
    output logic [PG_W-1:0]    reg_rdata,
    input  logic               ld_en,
    input  logic [PG_W-1:0]    ld_page,
    input  logic [LOC_W-1:0]   loc_addr,
    output logic [GLB_W-1:0]   glb_addr,
    output logic [2:0]         region
);

    logic [NPAGE*PG_W-1:0] pages;
    logic                  hi_map;
    win_e                  win;

    pgx_page_bank #(
        .PW      (PG_W),
        .NP      (NPAGE),
        .RST_VAL ({8'hFE, 8'hFD, 8'hFE})
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .ld_en     (ld_en),
        .ld_page   (ld_page),
        .pages     (pages),
        .hi_map    (hi_map),
        .reg_rdata (reg_rdata)
    );

    pgx_win_decode #(
        .LW (LOC_W)
    ) u_dec (
        .loc (loc_addr),
        .win (win)
    );

    pgx_addr_compose #(
        .LW (LOC_W),
        .PW (PG_W),
        .GW (GLB_W)
    ) u_cmp (
        .win    (win),
        .loc    (loc_addr),
        .pages  (pages),
        .hi_map (hi_map),
        .glb    (glb_addr)
    );

    assign region = win;

endmodule

// File: rtl/pgx_translator_chk.sv
module pgx_translator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_sel,
    input logic [7:0]  reg_wdata,
    input logic [7:0]  reg_rdata,
    input logic        ld_en,
    input logic [7:0]  ld_page,
    input logic [15:0] loc_addr,
    input logic [22:0] glb_addr,
    input logic [2:0]  region
);

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        glb_addr[9:0] == loc_addr[9:0]); // R6

    AST_TOP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_addr[15:14] == 2'b11) |-> (glb_addr[22:14] == 9'h1FF && region == 3'd3)); // R2

    AST_MID_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_addr[15:14] == 2'b01) |-> (glb_addr[22:14] == 9'h1FD || glb_addr[22:14] == 9'h051)); // R3

    AST_PROG_TOPBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_addr[15:14] == 2'b10) |-> (glb_addr[22] && region == 3'd0)); // R1

    AST_RAM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_addr[15:12] == 4'h1) |-> (glb_addr[22:20] == 3'b000 && region == 3'd1)); // R4

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (loc_addr[15:14] != 2'b10 || glb_addr[21:14] == $past(ld_page))); // R8

    AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        region <= 3'd4); // R10

    AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !ld_en) |=> (!$stable(reg_sel) || $stable(reg_rdata))); // R7

    AST_CTL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd3) |-> (reg_rdata[7:1] == 7'd0)); // R11

endmodule

bind pgx_translator pgx_translator_chk u_chk (.*);

// File: tb/pgx_translator_test.sv
module pgx_translator_test;

    localparam int CLK_P = 10;
    localparam int NV    = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_page = 8'd0;
    logic [15:0] loc_addr = 16'd0;
    logic [22:0] glb_addr;
    logic [2:0]  region;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pgx_translator uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ld_en     (ld_en),
        .ld_page   (ld_page),
        .loc_addr  (loc_addr),
        .glb_addr  (glb_addr),
        .region    (region)
    );

    // Pages during the table walk: program 0x12, RAM 0x34, nonvolatile 0x56, map-select 0.
    localparam logic [15:0] V_LOC [NV] = '{
        16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF, 16'h4000,
        16'h7ABC, 16'h1000, 16'h1FFF, 16'h0800, 16'h0BFF,
        16'h0000, 16'h07FF, 16'h0C00, 16'h2000, 16'h3FFF};
    localparam logic [22:0] V_GLB [NV] = '{
        23'h448000, 23'h44BFFF, 23'h7FC000, 23'h7FFFFF, 23'h7F4000,
        23'h7F7ABC, 23'h034000, 23'h034FFF, 23'h115800, 23'h115BFF,
        23'h7F0000, 23'h7F07FF, 23'h7F0C00, 23'h7F2000, 23'h7F3FFF};
    localparam logic [2:0] V_REG [NV] = '{
        3'd0, 3'd0, 3'd3, 3'd3, 3'd3,
        3'd3, 3'd1, 3'd1, 3'd2, 3'd2,
        3'd4, 3'd4, 3'd4, 3'd4, 3'd4};
    localparam string V_REQ [NV] = '{
        "R1", "R1", "R2", "R2", "R3",
        "R3", "R4", "R4", "R5", "R5",
        "R6", "R6", "R6", "R6", "R6"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [7:0] dat);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = dat;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input string req, input logic [1:0] sel, input logic [7:0] exp);
        @(negedge clk);
        reg_sel = sel;
        #1;
        check(req, {24'd0, reg_rdata}, {24'd0, exp});
    endtask

    task automatic xlate(input string req, input logic [15:0] a,
                         input logic [22:0] eg, input logic [2:0] er);
        @(negedge clk);
        loc_addr = a;
        #1;
        check(req, {9'd0, glb_addr}, {9'd0, eg});
        check({req, "_R10"}, {29'd0, region}, {29'd0, er});
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset values
        read_reg("R9", 2'd0, 8'hFE);
        read_reg("R9", 2'd1, 8'hFD);
        read_reg("R9", 2'd2, 8'hFE);
        read_reg("R9", 2'd3, 8'h00);
        xlate("R9", 16'h8000, 23'h7F8000, 3'd0);

        // R7 register writes and read back
        bus_write(2'd0, 8'h12);
        bus_write(2'd1, 8'h34);
        bus_write(2'd2, 8'h56);
        read_reg("R7", 2'd0, 8'h12);
        read_reg("R7", 2'd1, 8'h34);
        read_reg("R7", 2'd2, 8'h56);

        for (int i = 0; i < NV; i++) begin
            xlate(V_REQ[i], V_LOC[i], V_GLB[i], V_REG[i]);
        end

        // R11 map-select register keeps only bit 0, pages untouched
        bus_write(2'd3, 8'hFF);
        read_reg("R11", 2'd3, 8'h01);
        read_reg("R11", 2'd0, 8'h12);
        read_reg("R11", 2'd1, 8'h34);
        read_reg("R11", 2'd2, 8'h56);

        // R3 relocated region; R2 top region unaffected by map-select
        xlate("R3", 16'h4000, 23'h144000, 3'd3);
        xlate("R3", 16'h7FFF, 23'h147FFF, 3'd3);
        xlate("R2", 16'hC123, 23'h7FC123, 3'd3);

        // R8 load port
        @(negedge clk);
        ld_en = 1'b1; ld_page = 8'h80;
        @(negedge clk);
        ld_en = 1'b0;
        xlate("R8", 16'h8000, 23'h600000, 3'd0);

        // R8 priority over a same-cycle bus write
        @(negedge clk);
        ld_en = 1'b1; ld_page = 8'h22;
        reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h11;
        @(negedge clk);
        ld_en = 1'b0; reg_wr = 1'b0;
        read_reg("R8", 2'd0, 8'h22);
        xlate("R8", 16'h8123, 23'h488123, 3'd0);
        xlate("R2", 16'hFFFF, 23'h7FFFFF, 3'd3);

        // R3 back to the default map
        bus_write(2'd3, 8'hFE);
        xlate("R3", 16'h5555, 23'h7F5555, 3'd3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule